// File: doc/BRIEF.md
# Peripheral protection attribute bank

This block holds the per-port security attributes for ten peripheral protection controllers: two internal APB controllers, four APB expansion controllers and four AHB expansion controllers. For each controller it keeps three port masks. A non-secure mask marks which ports belong to the non-secure world. A secure-privileged mask and a non-secure-privileged mask say which ports need privileged access. Gating logic outside this block uses the per-port non-secure and access-privilege outputs.

Two independent 4 KB register windows reach the masks. The secure window reads and writes the non-secure and secure-privileged masks. The non-secure window reaches only the non-secure-privileged masks. Each window is a single-cycle bus with select, write, byte address, access size, 32-bit write data and registered read data. The privilege output of each port comes from the non-secure-privileged bit when the port is non-secure, and from the secure-privileged bit when it is not.

Top module: `ppc_attr_bank`

## Requirements
- R1: After reset, every mask of every controller is zero: all non-secure and privilege outputs are 0 and every mask reads as 0.
- R2: A secure-window word write sets a non-secure mask. AHB expansion controllers sit at 0x60/0x64/0x68/0x6C, internal APB controllers at 0x70/0x74, and APB expansion controllers at 0x80/0x84/0x88/0x8C. Address bits [3:2] select the controller. Each port's non-secure output equals its stored bit (port p of controller i is output bit i*PORTS+p), and the mask reads back at the same offset.
- R3: The secure window writes and reads the secure-privileged masks at 0xA0-0xAC (AHB expansion), 0xB0-0xB4 (internal APB) and 0xC0-0xCC (APB expansion).
- R4: The non-secure window writes and reads the non-secure-privileged masks at those same offsets (0xA0-0xCC). A non-secure-window write to any other offset changes no mask.
- R5: A written value is truncated to the controller's port count, so the bits above it read as zero.
- R6: Each port's privilege output is its non-secure-privileged bit when its non-secure bit is 1, and its secure-privileged bit otherwise. The output updates after a write to any of the three masks.
- R7: A write whose size code is byte (0) or halfword (1) changes nothing. Only size code 2 (word) with address bits [1:0] = 0 writes.
- R8: A byte read returns register bits [8*a+7:8*a], where a is address bits [1:0]. A halfword read returns bits [8*a+15:8*a], zero-extended. A word read returns the whole register.
- R9: Offsets 0x50 and 0x90 in the secure window, 0x90 in the non-secure window, the unused internal slots 0x78/0x7C and any other unmapped offset read as zero. Writes to them change no mask.
- R10: Read data is registered. It appears on the read-data port in the cycle after a read is selected and stays unchanged until the next read on that window.
- R11: Writes on both windows in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sSel | input | 1 | Secure window access select |
| sWrite | input | 1 | Secure window write (1) or read (0) |
| sAddr | input | 12 | Secure window byte address |
| sSize | input | 2 | Secure window access size: 0 byte, 1 half, 2 word |
| sWdata | input | 32 | Secure window write data |
| sRdata | output | 32 | Secure window registered read data |
| nSel | input | 1 | Non-secure window access select |
| nWrite | input | 1 | Non-secure window write (1) or read (0) |
| nAddr | input | 12 | Non-secure window byte address |
| nSize | input | 2 | Non-secure window access size |
| nWdata | input | 32 | Non-secure window write data |
| nRdata | output | 32 | Non-secure window registered read data |
| apbIntNonSec | output | 2*INT_PORTS | Per-port non-secure, internal APB controllers |
| apbIntPriv | output | 2*INT_PORTS | Per-port privilege, internal APB controllers |
| apbExpNonSec | output | 4*APB_EXP_PORTS | Per-port non-secure, APB expansion controllers |
| apbExpPriv | output | 4*APB_EXP_PORTS | Per-port privilege, APB expansion controllers |
| ahbExpNonSec | output | 4*AHB_EXP_PORTS | Per-port non-secure, AHB expansion controllers |
| ahbExpPriv | output | 4*AHB_EXP_PORTS | Per-port privilege, AHB expansion controllers |

## Verification
Two functions can fall in the same cycle. The secure window can write a controller's non-secure mask while the non-secure window writes that same controller's non-secure-privileged mask. The privilege output then depends on both new values at once. The bench provokes this by driving both writes in one clock. It then expects the privilege bits worked out from the new non-secure mask and the new non-secure-privileged mask together, and checks that neither write is lost or overwritten by the other.

// File: rtl/ppc_attr_pkg.sv
package ppc_attr_pkg;

  typedef enum logic [1:0] {
    GRP_NONE    = 2'd0,
    GRP_APB_INT = 2'd1,
    GRP_APB_EXP = 2'd2,
    GRP_AHB_EXP = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    MSK_NS  = 2'd0,
    MSK_SP  = 2'd1,
    MSK_NSP = 2'd2
  } msk_e;

  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam int         INT_CNT   = 2;
  localparam int         EXP_CNT   = 4;

  // Strobes from decode to the mask storage, one per window
  typedef struct packed {
    logic       wr;
    logic       rd;
    grp_e       grp;
    msk_e       msk;
    logic [1:0] idx;
    logic [1:0] lane;
    logic [1:0] size;
  } acc_t;

endpackage

// File: rtl/ppc_attr_ctrl.sv
module ppc_attr_ctrl
  import ppc_attr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sSel,
  input  logic        sWrite,
  input  logic [11:0] sAddr,
  input  logic [1:0]  sSize,
  input  logic        nSel,
  input  logic        nWrite,
  input  logic [11:0] nAddr,
  input  logic [1:0]  nSize,
  output acc_t        sAcc,
  output acc_t        nAcc
);

  grp_e sGrp, nGrp;
  msk_e sMsk;

  // Secure window map: non-secure masks and secure-privileged masks
  always_comb begin
    sGrp = GRP_NONE;
    sMsk = MSK_NS;
    unique case (sAddr[11:4])
      8'h06: sGrp = GRP_AHB_EXP;
      8'h07: sGrp = (sAddr[3:2] < 2'(INT_CNT)) ? GRP_APB_INT : GRP_NONE;
      8'h08: sGrp = GRP_APB_EXP;
      8'h0A: begin sGrp = GRP_AHB_EXP; sMsk = MSK_SP; end
      8'h0B: begin
        sGrp = (sAddr[3:2] < 2'(INT_CNT)) ? GRP_APB_INT : GRP_NONE;
        sMsk = MSK_SP;
      end
      8'h0C: begin sGrp = GRP_APB_EXP; sMsk = MSK_SP; end
      default: sGrp = GRP_NONE;
    endcase
  end

  // Non-secure window map: only the non-secure-privileged masks
  always_comb begin
    unique case (nAddr[11:4])
      8'h0A:   nGrp = GRP_AHB_EXP;
      8'h0B:   nGrp = (nAddr[3:2] < 2'(INT_CNT)) ? GRP_APB_INT : GRP_NONE;
      8'h0C:   nGrp = GRP_APB_EXP;
      default: nGrp = GRP_NONE;
    endcase
  end

  always_comb begin
    sAcc.wr   = sSel && sWrite && (sSize == SIZE_WORD) && (sAddr[1:0] == 2'b00)
                && (sGrp != GRP_NONE);
    sAcc.rd   = sSel && !sWrite;
    sAcc.grp  = sGrp;
    sAcc.msk  = sMsk;
    sAcc.idx  = sAddr[3:2];
    sAcc.lane = sAddr[1:0];
    sAcc.size = sSize;

    nAcc.wr   = nSel && nWrite && (nSize == SIZE_WORD) && (nAddr[1:0] == 2'b00)
                && (nGrp != GRP_NONE);
    nAcc.rd   = nSel && !nWrite;
    nAcc.grp  = nGrp;
    nAcc.msk  = MSK_NSP;
    nAcc.idx  = nAddr[3:2];
    nAcc.lane = nAddr[1:0];
    nAcc.size = nSize;
  end

  // R7: sub-word writes never raise a write strobe
  a_r7_narrow_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (sSel && sWrite && sSize != SIZE_WORD) |-> !sAcc.wr);
  a_r7_narrow_no_strobe_ns: assert property (@(posedge clk) disable iff (!rstN)
    (nSel && nWrite && nSize != SIZE_WORD) |-> !nAcc.wr);

endmodule

// File: rtl/ppc_attr_datapath.sv
module ppc_attr_datapath
  import ppc_attr_pkg::*;
#(
  parameter int INT_PORTS     = 12,
  parameter int APB_EXP_PORTS = 16,
  parameter int AHB_EXP_PORTS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  acc_t        sAcc,
  input  acc_t        nAcc,
  input  logic [31:0] sWdata,
  input  logic [31:0] nWdata,
  output logic [31:0] sRdata,
  output logic [31:0] nRdata,
  output logic [INT_CNT*INT_PORTS-1:0]     apbIntNonSec,
  output logic [INT_CNT*INT_PORTS-1:0]     apbIntPriv,
  output logic [EXP_CNT*APB_EXP_PORTS-1:0] apbExpNonSec,
  output logic [EXP_CNT*APB_EXP_PORTS-1:0] apbExpPriv,
  output logic [EXP_CNT*AHB_EXP_PORTS-1:0] ahbExpNonSec,
  output logic [EXP_CNT*AHB_EXP_PORTS-1:0] ahbExpPriv
);

  logic [INT_PORTS-1:0]     intNs [INT_CNT];
  logic [INT_PORTS-1:0]     intSp [INT_CNT];
  logic [INT_PORTS-1:0]     intNsp[INT_CNT];
  logic [APB_EXP_PORTS-1:0] apbNs [EXP_CNT];
  logic [APB_EXP_PORTS-1:0] apbSp [EXP_CNT];
  logic [APB_EXP_PORTS-1:0] apbNsp[EXP_CNT];
  logic [AHB_EXP_PORTS-1:0] ahbNs [EXP_CNT];
  logic [AHB_EXP_PORTS-1:0] ahbSp [EXP_CNT];
  logic [AHB_EXP_PORTS-1:0] ahbNsp[EXP_CNT];

  logic [31:0] sWord, nWord, sRdNext, nRdNext;

  // Mask storage; stored width is the port count, so truncation is free
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < INT_CNT; i++) begin
        intNs[i] <= '0; intSp[i] <= '0; intNsp[i] <= '0;
      end
      for (int i = 0; i < EXP_CNT; i++) begin
        apbNs[i] <= '0; apbSp[i] <= '0; apbNsp[i] <= '0;
        ahbNs[i] <= '0; ahbSp[i] <= '0; ahbNsp[i] <= '0;
      end
    end else begin
      if (sAcc.wr) begin
        unique case (sAcc.grp)
          GRP_APB_INT: if (sAcc.msk == MSK_NS) intNs[sAcc.idx[0]] <= sWdata[INT_PORTS-1:0];
                       else                    intSp[sAcc.idx[0]] <= sWdata[INT_PORTS-1:0];
          GRP_APB_EXP: if (sAcc.msk == MSK_NS) apbNs[sAcc.idx] <= sWdata[APB_EXP_PORTS-1:0];
                       else                    apbSp[sAcc.idx] <= sWdata[APB_EXP_PORTS-1:0];
          GRP_AHB_EXP: if (sAcc.msk == MSK_NS) ahbNs[sAcc.idx] <= sWdata[AHB_EXP_PORTS-1:0];
                       else                    ahbSp[sAcc.idx] <= sWdata[AHB_EXP_PORTS-1:0];
          default: ;
        endcase
      end
      if (nAcc.wr && nAcc.msk == MSK_NSP) begin
        unique case (nAcc.grp)
          GRP_APB_INT: intNsp[nAcc.idx[0]] <= nWdata[INT_PORTS-1:0];
          GRP_APB_EXP: apbNsp[nAcc.idx]    <= nWdata[APB_EXP_PORTS-1:0];
          GRP_AHB_EXP: ahbNsp[nAcc.idx]    <= nWdata[AHB_EXP_PORTS-1:0];
          default: ;
        endcase
      end
    end
  end

  // Read selection, then lane extraction for narrow reads
  always_comb begin
    unique case (sAcc.grp)
      GRP_APB_INT: sWord = (sAcc.msk == MSK_NS) ? 32'(intNs[sAcc.idx[0]]) : 32'(intSp[sAcc.idx[0]]);
      GRP_APB_EXP: sWord = (sAcc.msk == MSK_NS) ? 32'(apbNs[sAcc.idx])    : 32'(apbSp[sAcc.idx]);
      GRP_AHB_EXP: sWord = (sAcc.msk == MSK_NS) ? 32'(ahbNs[sAcc.idx])    : 32'(ahbSp[sAcc.idx]);
      default:     sWord = '0;
    endcase
    unique case (nAcc.grp)
      GRP_APB_INT: nWord = 32'(intNsp[nAcc.idx[0]]);
      GRP_APB_EXP: nWord = 32'(apbNsp[nAcc.idx]);
      GRP_AHB_EXP: nWord = 32'(ahbNsp[nAcc.idx]);
      default:     nWord = '0;
    endcase
  end

  function automatic logic [31:0] laneOf(logic [31:0] w, logic [1:0] lane, logic [1:0] size);
    logic [31:0] sh;
    sh = w >> {lane, 3'b000};
    if (size == SIZE_WORD)      return w;
    else if (size == SIZE_HALF) return {16'b0, sh[15:0]};
    else                        return {24'b0, sh[7:0]};
  endfunction

  assign sRdNext = laneOf(sWord, sAcc.lane, sAcc.size);
  assign nRdNext = laneOf(nWord, nAcc.lane, nAcc.size);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sRdata <= '0;
      nRdata <= '0;
    end else begin
      if (sAcc.rd) sRdata <= sRdNext;
      if (nAcc.rd) nRdata <= nRdNext;
    end
  end

  // Per-port outputs: privilege picks between the two privilege masks
  for (genvar i = 0; i < INT_CNT; i++) begin : gInt
    assign apbIntNonSec[i*INT_PORTS +: INT_PORTS] = intNs[i];
    assign apbIntPriv[i*INT_PORTS +: INT_PORTS]   = (intNs[i] & intNsp[i]) | (~intNs[i] & intSp[i]);
  end
  for (genvar i = 0; i < EXP_CNT; i++) begin : gExp
    assign apbExpNonSec[i*APB_EXP_PORTS +: APB_EXP_PORTS] = apbNs[i];
    assign apbExpPriv[i*APB_EXP_PORTS +: APB_EXP_PORTS]   = (apbNs[i] & apbNsp[i]) | (~apbNs[i] & apbSp[i]);
    assign ahbExpNonSec[i*AHB_EXP_PORTS +: AHB_EXP_PORTS] = ahbNs[i];
    assign ahbExpPriv[i*AHB_EXP_PORTS +: AHB_EXP_PORTS]   = (ahbNs[i] & ahbNsp[i]) | (~ahbNs[i] & ahbSp[i]);

    // R2: a secure write strobe to this AHB slot shows on its non-secure outputs next cycle
    a_r2_ns_write_visible: assert property (@(posedge clk) disable iff (!rstN)
      (sAcc.wr && sAcc.grp == GRP_AHB_EXP && sAcc.msk == MSK_NS && sAcc.idx == 2'(i))
      |=> ahbExpNonSec[i*AHB_EXP_PORTS +: AHB_EXP_PORTS] == $past(sWdata[AHB_EXP_PORTS-1:0]));
  end

  // R6: privilege outputs move only after a mask write
  a_r6_priv_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !(sAcc.wr || nAcc.wr) |=> ($stable(apbIntPriv) && $stable(apbExpPriv) && $stable(ahbExpPriv)));

  // R4: the non-secure window alone never alters non-secure outputs
  a_r4_nswin_keeps_ns: assert property (@(posedge clk) disable iff (!rstN)
    (nAcc.wr && !sAcc.wr) |=> ($stable(apbIntNonSec) && $stable(apbExpNonSec) && $stable(ahbExpNonSec)));

  // R10: read data holds while no read is selected
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sAcc.rd |=> $stable(sRdata));
  a_r10_rdata_hold_ns: assert property (@(posedge clk) disable iff (!rstN)
    !nAcc.rd |=> $stable(nRdata));

endmodule

// File: rtl/ppc_attr_bank.sv
module ppc_attr_bank
  import ppc_attr_pkg::*;
#(
  parameter int INT_PORTS     = 12,
  parameter int APB_EXP_PORTS = 16,
  parameter int AHB_EXP_PORTS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sSel,
  input  logic        sWrite,
  input  logic [11:0] sAddr,
  input  logic [1:0]  sSize,
  input  logic [31:0] sWdata,
  output logic [31:0] sRdata,
  input  logic        nSel,
  input  logic        nWrite,
  input  logic [11:0] nAddr,
  input  logic [1:0]  nSize,
  input  logic [31:0] nWdata,
  output logic [31:0] nRdata,
  output logic [2*INT_PORTS-1:0]     apbIntNonSec,
  output logic [2*INT_PORTS-1:0]     apbIntPriv,
  output logic [4*APB_EXP_PORTS-1:0] apbExpNonSec,
  output logic [4*APB_EXP_PORTS-1:0] apbExpPriv,
  output logic [4*AHB_EXP_PORTS-1:0] ahbExpNonSec,
  output logic [4*AHB_EXP_PORTS-1:0] ahbExpPriv
);

  acc_t sAcc, nAcc;

  ppc_attr_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .sSel(sSel), .sWrite(sWrite), .sAddr(sAddr), .sSize(sSize),
    .nSel(nSel), .nWrite(nWrite), .nAddr(nAddr), .nSize(nSize),
    .sAcc(sAcc), .nAcc(nAcc)
  );

  ppc_attr_datapath #(
    .INT_PORTS(INT_PORTS), .APB_EXP_PORTS(APB_EXP_PORTS), .AHB_EXP_PORTS(AHB_EXP_PORTS)
  ) uData (
    .clk(clk), .rstN(rstN), .sAcc(sAcc), .nAcc(nAcc),
    .sWdata(sWdata), .nWdata(nWdata), .sRdata(sRdata), .nRdata(nRdata),
    .apbIntNonSec(apbIntNonSec), .apbIntPriv(apbIntPriv),
    .apbExpNonSec(apbExpNonSec), .apbExpPriv(apbExpPriv),
    .ahbExpNonSec(ahbExpNonSec), .ahbExpPriv(ahbExpPriv)
  );

endmodule

// File: tb/tb_ppc_attr_bank.sv
module tb_ppc_attr_bank;

  localparam int IP = 12;
  localparam int XP = 16;
  localparam int HP = 16;

  logic        clk = 0;
  logic        rstN = 0;
  logic        sSel = 0, sWrite = 0, nSel = 0, nWrite = 0;
  logic [11:0] sAddr = '0, nAddr = '0;
  logic [1:0]  sSize = 2'd2, nSize = 2'd2;
  logic [31:0] sWdata = '0, nWdata = '0;
  logic [31:0] sRdata, nRdata;
  logic [2*IP-1:0] apbIntNonSec, apbIntPriv;
  logic [4*XP-1:0] apbExpNonSec, apbExpPriv;
  logic [4*HP-1:0] ahbExpNonSec, ahbExpPriv;

  ppc_attr_bank #(.INT_PORTS(IP), .APB_EXP_PORTS(XP), .AHB_EXP_PORTS(HP)) dut (
    .clk(clk), .rstN(rstN),
    .sSel(sSel), .sWrite(sWrite), .sAddr(sAddr), .sSize(sSize), .sWdata(sWdata), .sRdata(sRdata),
    .nSel(nSel), .nWrite(nWrite), .nAddr(nAddr), .nSize(nSize), .nWdata(nWdata), .nRdata(nRdata),
    .apbIntNonSec(apbIntNonSec), .apbIntPriv(apbIntPriv),
    .apbExpNonSec(apbExpNonSec), .apbExpPriv(apbExpPriv),
    .ahbExpNonSec(ahbExpNonSec), .ahbExpPriv(ahbExpPriv)
  );

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  bit          nsQ[$];
  bit          pending = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read results as the registered data appears
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (pending && expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        bit w;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        w = nsQ.pop_front();
        chk(t, w ? nRdata : sRdata, e);
        pending = 0;
      end
    end
  end

  task automatic sWr(logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    @(negedge clk);
    sSel = 1; sWrite = 1; sAddr = a; sWdata = d; sSize = sz;
    @(posedge clk); #1;
    sSel = 0; sWrite = 0;
  endtask

  task automatic nWr(logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    @(negedge clk);
    nSel = 1; nWrite = 1; nAddr = a; nWdata = d; nSize = sz;
    @(posedge clk); #1;
    nSel = 0; nWrite = 0;
  endtask

  task automatic rd(bit ns, logic [11:0] a, logic [1:0] sz, logic [31:0] exp, string tag);
    @(negedge clk);
    if (ns) begin nSel = 1; nWrite = 0; nAddr = a; nSize = sz; end
    else    begin sSel = 1; sWrite = 0; sAddr = a; sSize = sz; end
    expQ.push_back(exp); tagQ.push_back(tag); nsQ.push_back(ns);
    pending = 1;
    @(posedge clk); #1;
    sSel = 0; nSel = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ahb ns", 32'(ahbExpNonSec[31:0]), 0);
    chk("R1 int priv", 32'(apbIntPriv), 0);
    chk("R1 apb ns", apbExpNonSec[31:0], 0);
    rd(0, 12'h064, 2, 0, "R1 read ns mask");
    rd(1, 12'h0A4, 2, 0, "R1 read nsp mask");

    // R2 non-secure masks
    sWr(12'h064, 32'h0000A5A5);
    chk("R2 ahb1 ns out", 32'(ahbExpNonSec[31:16]), 32'hA5A5);
    chk("R2 ahb0 untouched", 32'(ahbExpNonSec[15:0]), 0);
    rd(0, 12'h064, 2, 32'hA5A5, "R2 readback 0x64");
    sWr(12'h084, 32'h00001234);
    chk("R2 apbexp1 ns out", 32'(apbExpNonSec[31:16]), 32'h1234);
    rd(0, 12'h084, 2, 32'h1234, "R2 readback 0x84");

    // R5 truncation to port count
    sWr(12'h074, 32'hFFFFFFFF);
    rd(0, 12'h074, 2, 32'h00000FFF, "R5 truncated readback");
    chk("R5 int1 ns out", 32'(apbIntNonSec[23:12]), 32'hFFF);

    // R3 secure-privileged masks
    sWr(12'h0A4, 32'h000000FF);
    rd(0, 12'h0A4, 2, 32'h00FF, "R3 sp readback");
    sWr(12'h0C8, 32'h0000BEEF);
    rd(0, 12'h0C8, 2, 32'hBEEF, "R3 apbexp2 sp readback");

    // R4 non-secure-privileged masks
    nWr(12'h0A4, 32'h00000F0F);
    rd(1, 12'h0A4, 2, 32'h0F0F, "R4 nsp readback");
    rd(0, 12'h0A4, 2, 32'h00FF, "R4 sp unaffected");

    // R6 privilege select: (A5A5 & 0F0F) | (~A5A5 & 00FF) = 055F
    chk("R6 ahb1 priv", 32'(ahbExpPriv[31:16]), 32'h055F);
    chk("R6 int1 priv zero", 32'(apbIntPriv[23:12]), 0);
    nWr(12'h0B4, 32'h000000F0);
    chk("R6 int1 priv from nsp", 32'(apbIntPriv[23:12]), 32'h0F0);
    rd(1, 12'h0B4, 2, 32'h0F0, "R4 int nsp readback");

    // R4 non-secure window cannot reach other masks
    nWr(12'h064, 32'h0);
    nWr(12'h0D0, 32'hFFFFFFFF);
    rd(0, 12'h064, 2, 32'hA5A5, "R4 ns-window write ignored");
    chk("R4 ahb1 ns out kept", 32'(ahbExpNonSec[31:16]), 32'hA5A5);

    // R7 narrow writes ignored
    sWr(12'h064, 32'h0, 2'd0);
    sWr(12'h064, 32'h0, 2'd1);
    nWr(12'h0A4, 32'h0, 2'd0);
    rd(0, 12'h064, 2, 32'hA5A5, "R7 byte/half secure write ignored");
    rd(1, 12'h0A4, 2, 32'h0F0F, "R7 byte ns write ignored");
    chk("R7 ahb1 priv kept", 32'(ahbExpPriv[31:16]), 32'h055F);

    // R8 lane extraction
    rd(0, 12'h065, 0, 32'hA5, "R8 byte lane1");
    rd(0, 12'h085, 0, 32'h12, "R8 byte lane1 apbexp");
    rd(0, 12'h084, 0, 32'h34, "R8 byte lane0");
    rd(0, 12'h084, 1, 32'h1234, "R8 half lane0");
    rd(0, 12'h086, 1, 32'h0, "R8 half lane2");
    rd(1, 12'h0A5, 0, 32'h0F, "R8 ns byte lane1");

    // R9 reserved and unmapped offsets
    sWr(12'h050, 32'hFFFFFFFF);
    sWr(12'h090, 32'hFFFFFFFF);
    sWr(12'h078, 32'hFFFFFFFF);
    nWr(12'h090, 32'hFFFFFFFF);
    rd(0, 12'h050, 2, 0, "R9 0x50 zero");
    rd(0, 12'h090, 2, 0, "R9 0x90 zero");
    rd(0, 12'h078, 2, 0, "R9 0x78 zero");
    rd(1, 12'h090, 2, 0, "R9 ns 0x90 zero");
    rd(0, 12'h070, 2, 0, "R9 int0 untouched");
    chk("R9 int0 ns out", 32'(apbIntNonSec[11:0]), 0);

    // R10 registered and held read data
    rd(0, 12'h084, 2, 32'h1234, "R10 read");
    @(negedge clk);
    chk("R10 held idle", sRdata, 32'h1234);
    sWr(12'h084, 32'h00005678);
    chk("R10 held across write", sRdata, 32'h1234);
    rd(0, 12'h084, 2, 32'h5678, "R10 new read");

    // R11 both windows in one cycle on the same controller
    @(negedge clk);
    sSel = 1; sWrite = 1; sAddr = 12'h060; sWdata = 32'h3; sSize = 2;
    nSel = 1; nWrite = 1; nAddr = 12'h0A0; nWdata = 32'h1; nSize = 2;
    @(posedge clk); #1;
    sSel = 0; sWrite = 0; nSel = 0; nWrite = 0;
    chk("R11 ahb0 ns", 32'(ahbExpNonSec[15:0]), 32'h3);
    chk("R11 ahb0 priv", 32'(ahbExpPriv[15:0]), 32'h1);
    rd(1, 12'h0A0, 2, 32'h1, "R11 nsp kept");

    // R1 reset mid-run
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 ns cleared", 32'(ahbExpNonSec[31:0]), 0);
    chk("R1 priv cleared", 32'(apbIntPriv), 0);
    rd(0, 12'h064, 2, 0, "R1 mask cleared");
    rd(1, 12'h0A4, 2, 0, "R1 nsp cleared");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule